// File: doc/BRIEF.md
# External interrupt sense controller

This block watches three external interrupt pins and turns the condition chosen for each into an interrupt request. Each pin first passes through a two-flop synchronizer. The block then looks for the selected condition. Pins 0 and 1 each have a two-bit sense field. The field selects a low level, a falling edge or a rising edge, and one code value disables triggering. Pin 2 can only detect edges, and one select bit picks the edge direction.

An edge event sets a pending flag for its pin. The flag stays set until the vector for that pin is acknowledged, or until software clears it by writing a one. Low-level mode keeps no flag. In that mode the request follows the synchronized pin and stays asserted for as long as the pin is low. A request reaches the output only when both the global enable and the enable for that pin are set.

The block sees the pin level whatever the pin direction. Software can therefore raise an interrupt by driving a pin that is configured as an output.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset all pending flags and all requests are 0, provided the pins are held high.
- R2: A pin change first affects the block two rising clock edges after it is applied. In low-level mode the request rises after the second edge.
- R3: For pins 0 and 1, sense code 2'b10 selects the falling edge. A high-to-low transition of the synchronized pin sets the pending flag after the next clock edge, which is three edges after the pin change.
- R4: For pins 0 and 1, sense code 2'b11 selects the rising edge and sets the pending flag in the same way on a low-to-high transition.
- R5: Sense code 2'b01 is reserved. It never sets the pending flag and never raises a request.
- R6: Sense code 2'b00 is low level. The request follows the inverted synchronized pin, no pending flag is latched, and the request drops once the high pin has passed through the synchronizer.
- R7: Pin 2 is edge-only. Select bit `sense2_rise_i`=0 selects the falling edge and 1 selects the rising edge. Its request is never raised without its pending flag.
- R8: A pending flag clears on the clock edge where its `ack_i` or `clr_i` bit is 1. If a new edge event occurs in the same cycle, the flag stays set.
- R9: Request bit i is 1 only when `gie_i` and `en_i[i]` are both 1. Pending flags are set whatever the enables.
- R10: The sense field for pin 1 is `sense_ctl_i[3:2]` and the sense field for pin 0 is `sense_ctl_i[1:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 3 | External interrupt pin levels |
| sense_ctl_i | input | 4 | Sense fields: pin 1 in [3:2], pin 0 in [1:0] |
| sense2_rise_i | input | 1 | Pin 2 edge select: 0 falling, 1 rising |
| en_i | input | 3 | Per-pin request enables |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Per-vector acknowledge, clears the pending flag |
| clr_i | input | 3 | Write-one-to-clear strobes for the pending flags |
| pend_o | output | 3 | Pending flags |
| req_o | output | 3 | Interrupt requests |

## Verification
The bench targets the synchronizer latency. A design that drops a flop, or adds one, moves the level request and the edge flag by one cycle, so the cycle-exact comparison fails. It also targets a clear that arrives in the same cycle as a new edge. A design that gives the clear priority loses that event. Further cases are the reserved code and level mode, where a design that latches a flag would keep requesting after the pin returns high, and a swapped pair of sense fields, which would make the wrong pin respond. Random toggling of pins, modes, enables and clears is checked every cycle against a reference model built from the requirements.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pin_i,
  input  logic [3:0] sense_ctl_i,
  input  logic       sense2_rise_i,
  input  logic [2:0] en_i,
  input  logic       gie_i,
  input  logic [2:0] ack_i,
  input  logic [2:0] clr_i,
  output logic [2:0] pend_o,
  output logic [2:0] req_o
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] sync_q [SYNC_STAGES];
  logic [NPIN-1:0] prev_q, pend_q, lvl, fall, rise, edge_evt, is_level;
  logic [1:0]      mode0, mode1;

  assign lvl   = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~lvl;
  assign rise  = ~prev_q & lvl;
  assign mode0 = sense_ctl_i[1:0];
  assign mode1 = sense_ctl_i[3:2];

  assign edge_evt[0] = mode0[1] & (mode0[0] ? rise[0] : fall[0]);
  assign edge_evt[1] = mode1[1] & (mode1[0] ? rise[1] : fall[1]);
  assign edge_evt[2] = sense2_rise_i ? rise[2] : fall[2];

  assign is_level = {1'b0, mode1 == 2'b00, mode0 == 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '1;
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= lvl;
      pend_q <= (pend_q & ~(ack_i | clr_i)) | edge_evt;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = {NPIN{gie_i}} & en_i &
                  ((is_level & ~lvl) | (~is_level & pend_q));
endmodule

module ext_irq_sense_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] sense_ctl_i,
  input logic [2:0] en_i,
  input logic       gie_i,
  input logic [2:0] ack_i,
  input logic [2:0] clr_i,
  input logic [2:0] pend_o,
  input logic [2:0] req_o
);
  a_r9_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o & ~(en_i & {3{gie_i}})) == 3'b000);

  a_r7_pin2_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_o[2] |-> pend_o[2]);

  a_r5_pin0_set_needs_edge_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o[0]) |-> $past(sense_ctl_i[1]));

  a_r10_pin1_set_needs_edge_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o[1]) |-> $past(sense_ctl_i[3]));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[0] && (ack_i[0] || clr_i[0]) && sense_ctl_i[1:0] == 2'b01) |=> !pend_o[0]);
endmodule

bind ext_irq_sense ext_irq_sense_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sense_ctl_i(sense_ctl_i), .en_i(en_i),
  .gie_i(gie_i), .ack_i(ack_i), .clr_i(clr_i), .pend_o(pend_o), .req_o(req_o)
);

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  logic       clk = 0, rst_n = 0;
  logic [2:0] pin_i = 3'b111, en_i = 0, ack_i = 0, clr_i = 0;
  logic [3:0] sense_ctl_i = 0;
  logic       sense2_rise_i = 0, gie_i = 0;
  logic [2:0] pend_o, req_o;
  int checks = 0, failures = 0;
  bit run_chk = 0;

  ext_irq_sense u_ext_irq_sense (.*);

  always #2 clk = ~clk;

  // reference model built from the requirements
  logic [2:0] m_s1 = 3'b111, m_s2 = 3'b111, m_prev = 3'b111, m_pend = 0;

  function automatic logic [1:0] mode_of(int i);
    return (i == 0) ? sense_ctl_i[1:0] : sense_ctl_i[3:2];
  endfunction

  function automatic logic exp_req(int i);
    if (!(gie_i && en_i[i])) return 1'b0;
    if (i < 2 && mode_of(i) == 2'b00) return ~m_s2[i];
    return m_pend[i];
  endfunction

  function automatic string tag_of(int i);
    if (!(gie_i && en_i[i])) return "R9";
    if (i == 2) return "R7";
    case (mode_of(i))
      2'b00: return "R6";
      2'b01: return "R5";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 3'b111; m_s2 = 3'b111; m_prev = 3'b111; m_pend = 0;
    end else begin
      logic [2:0] evt;
      for (int i = 0; i < 3; i++) begin
        logic f, r;
        f = m_prev[i] & ~m_s2[i];
        r = ~m_prev[i] & m_s2[i];
        if (i == 2) evt[i] = sense2_rise_i ? r : f;
        else evt[i] = (mode_of(i) == 2'b10) ? f : (mode_of(i) == 2'b11) ? r : 1'b0;
      end
      m_pend = (m_pend & ~(ack_i | clr_i)) | evt;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i;
    end
  end

  task automatic check(string req, logic [2:0] act, logic [2:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (run_chk) begin
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (req_o[i] !== exp_req(i)) begin
        failures++;
        $display("FAIL %s req[%0d] actual=%b expected=%b", tag_of(i), i, req_o[i], exp_req(i));
      end
    end
    check("R8", pend_o, m_pend, "pend");
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    step(3);
    check("R1", pend_o, 3'b000, "reset pend");
    check("R1", req_o, 3'b000, "reset req");
    rst_n = 1;
    step(2);
    check("R1", {pend_o, req_o}, 6'b0, "after reset");
    run_chk = 1;

    // R2 / R6: level mode latency and release
    gie_i = 1; en_i = 3'b111; sense_ctl_i = 4'b0101;
    step(1);
    sense_ctl_i = 4'b0100;
    pin_i[0] = 0;
    step(1);
    check("R2", req_o, 3'b000, "one edge after low");
    step(1);
    check("R2", req_o, 3'b001, "two edges after low");
    pin_i[0] = 1;
    step(2);
    check("R6", {pend_o[0], req_o[0]}, 2'b00, "level released, no latch");

    // R10 / R3: pin 1 falling, pin 0 reserved
    sense_ctl_i = 4'b1001;
    pin_i[1] = 0; pin_i[0] = 0;
    step(3);
    check("R10", pend_o, 3'b010, "only pin1 flagged");
    check("R5", req_o[0], 1'b0, "reserved no request");
    // R8: acknowledge clears
    ack_i = 3'b010; step(1); ack_i = 0;
    check("R8", pend_o, 3'b000, "ack clears");

    // R4 and R8 set-beats-clear: pin 0 rising, clear in the event cycle
    sense_ctl_i = 4'b0111; pin_i[0] = 1;
    step(2);
    clr_i = 3'b001; step(1); clr_i = 0;
    check("R8", pend_o[0], 1'b1, "set wins over clear");
    check("R4", req_o[0], 1'b1, "rising request");
    clr_i = 3'b001; step(1); clr_i = 0;
    check("R8", pend_o[0], 1'b0, "clear by write-one");

    // R7: pin 2 rising selected, falling ignored; R9: disabled still flags
    sense2_rise_i = 1; pin_i[2] = 0; step(4);
    check("R7", pend_o[2], 1'b0, "falling ignored in rising mode");
    gie_i = 0; pin_i[2] = 1; step(3);
    check("R9", {pend_o[2], req_o[2]}, 2'b10, "flag set, request gated");
    gie_i = 1; step(1);
    check("R9", req_o[2], 1'b1, "request once enabled");
    clr_i = 3'b111; step(1); clr_i = 0;

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) pin_i = pin_i ^ 3'($urandom_range(0, 7));
      if ($urandom_range(0, 40) == 0) sense_ctl_i = 4'($urandom);
      if ($urandom_range(0, 40) == 0) sense2_rise_i = 1'($urandom);
      if ($urandom_range(0, 20) == 0) en_i = 3'($urandom);
      if ($urandom_range(0, 30) == 0) gie_i = 1'($urandom);
      ack_i = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
      clr_i = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000;
      step(1);
    end
    run_chk = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule